// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Controller

This block divides a fast input clock by a programmable integer using two moduli. It contains a small prescaler that divides by P+1 while the modulus select is low and by P while it is high. It also contains a controller built from two down-counters. One counter sets the number of prescaler cycles in an output frame. The other sets how many of those cycles use the longer modulus. A frame therefore lasts N·P + A input clocks. The block emits one single-clock pulse per frame and exposes the modulus select it drives.

Every clock step in the block runs on the input clock. The prescaler output is a one-clock tick, and both counters step only on that tick. The modulus select is registered, and its value for each prescaler cycle is settled during the cycle before it. The prescaler reads the select only at the moment it starts a new cycle, so the slow decision logic has a full prescaler period to resolve. The N, A and P settings are copied into holding registers just before a frame boundary, which keeps each frame internally consistent.

Top module: `pulse_swallow_div`

## Requirements
- R1: While rst_ni is low, div_o is 0 and mod_o is 1.
- R2: With settings held stable, consecutive div_o pulses are exactly N·P + A input clocks apart (for example N=5, A=3, P=4 gives 23).
- R3: div_o is high for exactly one clock per frame and never for two clocks in a row.
- R4: When A is 0, mod_o stays 1 for the whole frame and the frame length is N·P.
- R5: mod_o is decided one prescaler cycle early. Over a frame window that starts at the div_o clock, mod_o is 0 for (A−1)(P+1) + L clocks when A > 0, where L is P+1 if A equals N and P otherwise. It is 0 for no clocks when A is 0.
- R6: When A equals N, every prescaler cycle in the frame uses P+1, so the frame lasts N·(P+1).
- R7: A settings change applied in the clock of a div_o pulse does not alter the frame that pulse starts. Once held, the new values govern the frames from the second following pulse onwards.
- R8: An N input of 0 is treated as 1, and a P input below 2 is treated as 2.
- R9: With A stepped through 0..P−1 and N ≥ P−1, the frame lengths form every consecutive integer from P(P−1) upward.
- R10: N=1 is supported: with A in {0,1} the frame lasts P + A clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-rate input clock being divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| n_i | input | NW | Total prescaler cycles per frame (N) |
| a_i | input | AW | Prescaler cycles per frame at P+1 (A), A ≤ N |
| p_i | input | PW | Prescaler base modulus (P) |
| div_o | output | 1 | One-clock pulse per output frame |
| mod_o | output | 1 | Modulus select: 0 selects P+1, 1 selects P |

## Verification
Several corner cases are targeted: A=0, A=N, N=1, clamped zero or tiny settings, and a sweep of consecutive ratios near P(P−1). A controller that switched the modulus in the same cycle as the counter state would be off by one in both the frame length and the number of low mod_o clocks. A controller that reloaded the wrong cycle would give A=N or N=1 frames one prescaler period too long or too short. Settings are changed in the clock of a div_o pulse, so a design that picked them up at once would corrupt the frame already running. A design that never clamped its inputs would hang or collapse on N=0 or P=1.

// File: rtl/dm_pkg.sv
package dm_pkg;
  typedef enum logic {
    ST_PRIME = 1'b0,
    ST_RUN   = 1'b1
  } ctrl_st_e;
endpackage

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] p_i,
  input  logic          mod_i,
  output logic          tick_o
);
  localparam int CW = PW + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len;

  assign tick_o = (cnt_q == '0);
  // modulus is read only when a new prescaler cycle starts
  assign len = mod_i ? {1'b0, p_i} : ({1'b0, p_i} + CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_o) cnt_q <= len - CW'(1);
    else cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/dm_frame_regs.sv
module dm_frame_regs #(
  parameter int NW = 10,
  parameter int AW = 6,
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [NW-1:0] n_i,
  input  logic [AW-1:0] a_i,
  input  logic [PW-1:0] p_i,
  output logic [NW-1:0] n_o,
  output logic [AW-1:0] a_o,
  output logic [PW-1:0] p_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_o <= NW'(1);
      a_o <= '0;
      p_o <= PW'(2);
    end else if (cap_i) begin
      n_o <= n_i;
      a_o <= a_i;
      p_o <= p_i;
    end
  end
endmodule

// File: rtl/dm_swallow_ctrl.sv
module dm_swallow_ctrl
  import dm_pkg::*;
#(
  parameter int NW = 10,
  parameter int AW = 6,
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [AW-1:0] a_live_i,
  input  logic [PW-1:0] p_live_i,
  input  logic [NW-1:0] n_sh_i,
  input  logic [AW-1:0] a_sh_i,
  input  logic [PW-1:0] p_sh_i,
  output logic [PW-1:0] p_sel_o,
  output logic          cap_o,
  output logic          mod_o,
  output logic          div_o
);
  ctrl_st_e      st_q, st_nx;
  logic [NW-1:0] n_q, n_nx;
  logic [AW-1:0] a_q, a_nx;
  logic [PW-1:0] p_frm_q, p_frm_nx;
  logic          mod_nx, reload, last;

  always_comb begin
    st_nx    = st_q;
    n_nx     = n_q;
    a_nx     = a_q;
    p_frm_nx = p_frm_q;
    p_sel_o  = p_frm_q;
    mod_nx   = mod_o;
    reload   = 1'b0;
    last     = 1'b0;
    if (tick_i) begin
      if (st_q == ST_PRIME) begin
        // first prescaler cycle after reset: just arm the first frame
        st_nx   = ST_RUN;
        n_nx    = NW'(1);
        a_nx    = '0;
        p_sel_o = p_live_i;
        last    = 1'b1;
      end else if (n_q == NW'(1)) begin
        reload   = 1'b1;
        n_nx     = n_sh_i;
        a_nx     = a_sh_i;
        p_sel_o  = p_sh_i;
        p_frm_nx = p_sh_i;
        last     = (n_sh_i == NW'(1));
      end else begin
        n_nx = n_q - NW'(1);
        a_nx = (a_q != '0) ? a_q - AW'(1) : '0;
        last = (n_nx == NW'(1));
      end
      // decision for the cycle after the one starting now
      mod_nx = last ? (a_live_i == '0) : !(a_nx > AW'(1));
    end
  end

  assign cap_o = tick_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PRIME;
      n_q     <= NW'(1);
      a_q     <= '0;
      p_frm_q <= PW'(2);
      mod_o   <= 1'b1;
      div_o   <= 1'b0;
    end else begin
      st_q    <= st_nx;
      n_q     <= n_nx;
      a_q     <= a_nx;
      p_frm_q <= p_frm_nx;
      mod_o   <= mod_nx;
      div_o   <= reload;
    end
  end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int NW = 10,
  parameter int AW = 6,
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] n_i,
  input  logic [AW-1:0] a_i,
  input  logic [PW-1:0] p_i,
  output logic          div_o,
  output logic          mod_o
);
  logic [NW-1:0] n_eff, n_sh;
  logic [AW-1:0] a_sh;
  logic [PW-1:0] p_eff, p_sh, p_sel;
  logic          pre_tick, cap;

  assign n_eff = (n_i == '0) ? NW'(1) : n_i;
  assign p_eff = (p_i < PW'(2)) ? PW'(2) : p_i;

  dm_prescaler #(.PW(PW)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .p_i    (p_sel),
    .mod_i  (mod_o),
    .tick_o (pre_tick)
  );

  dm_frame_regs #(.NW(NW), .AW(AW), .PW(PW)) u_frm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .n_i    (n_eff),
    .a_i    (a_i),
    .p_i    (p_eff),
    .n_o    (n_sh),
    .a_o    (a_sh),
    .p_o    (p_sh)
  );

  dm_swallow_ctrl #(.NW(NW), .AW(AW), .PW(PW)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (pre_tick),
    .a_live_i (a_i),
    .p_live_i (p_eff),
    .n_sh_i   (n_sh),
    .a_sh_i   (a_sh),
    .p_sh_i   (p_sh),
    .p_sel_o  (p_sel),
    .cap_o    (cap),
    .mod_o    (mod_o),
    .div_o    (div_o)
  );
endmodule

// File: rtl/dm_checker.sv
module dm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic div_o,
  input logic mod_o,
  input logic tick_i
);
  // R3: output pulse lasts one clock
  a_r3_div_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  // R2: a frame boundary only follows a prescaler cycle start
  a_r2_div_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_o) |-> $past(tick_i));

  // R5: modulus select only moves at a prescaler cycle start
  a_r5_mod_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mod_o) |-> $past(tick_i));

  // R8: prescaler cycle is never shorter than two clocks
  a_r8_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);
endmodule

bind pulse_swallow_div dm_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .div_o  (div_o),
  .mod_o  (mod_o),
  .tick_i (pre_tick)
);

// File: tb/pulse_swallow_div_tb_top.sv
module pulse_swallow_div_tb_top;
  localparam int NW = 10;
  localparam int AW = 6;
  localparam int PW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NW-1:0] n_r;
  logic [AW-1:0] a_r;
  logic [PW-1:0] p_r;
  logic          div_o, mod_o;

  int checks = 0, failures = 0;
  int frames = 0, per_q = 0, low_q = 0, run_cnt = 0, run_low = 0;
  int dbl_div = 0;
  logic prev_div = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  pulse_swallow_div #(.NW(NW), .AW(AW), .PW(PW)) dut_i (
    .clk_i (clk), .rst_ni(rst_n), .n_i(n_r), .a_i(a_r), .p_i(p_r),
    .div_o (div_o), .mod_o(mod_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (div_o && prev_div) dbl_div++;
      prev_div = div_o;
      if (div_o) begin
        per_q = run_cnt; low_q = run_low;
        run_cnt = 1; run_low = mod_o ? 0 : 1;
        frames++;
      end else begin
        run_cnt++;
        if (!mod_o) run_low++;
      end
    end
  end

  function automatic int cl_n(int n); return (n == 0) ? 1 : n; endfunction
  function automatic int cl_p(int p); return (p < 2) ? 2 : p; endfunction
  function automatic int exp_per(int n, int a, int p);
    return cl_n(n) * cl_p(p) + a;
  endfunction
  function automatic int exp_low(int n, int a, int p);
    int nn = cl_n(n), pp = cl_p(p);
    if (a == 0) return 0;
    return (a - 1) * (pp + 1) + ((nn <= a) ? pp + 1 : pp);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wait_frame();
    int t = frames + 1;
    wait (frames >= t);
  endtask

  task automatic run_case(int n, int a, int p, string tag);
    int on = int'(n_r), oa = int'(a_r), op = int'(p_r);
    wait_frame();
    n_r = NW'(n); a_r = AW'(a); p_r = PW'(p);
    wait_frame();
    check({"R7 running frame kept ", tag}, per_q, exp_per(on, oa, op));
    wait_frame();
    wait_frame();
    check({"R2 period ", tag}, per_q, exp_per(n, a, p));
    check({"R5 mod low clocks ", tag}, low_q, exp_low(n, a, p));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=hang expected=finish");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    n_r = NW'(5); a_r = AW'(3); p_r = PW'(4);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 div_o in reset", int'(div_o), 0);
    check("R1 mod_o in reset", int'(mod_o), 1);
    rst_n = 1'b1;

    run_case(5, 3, 4, "R2 N5 A3 P4");
    run_case(6, 0, 5, "R4 A=0");
    run_case(4, 4, 6, "R6 A=N");
    run_case(1, 1, 3, "R10 N=1 A=1");
    run_case(1, 0, 7, "R10 N=1 A=0");
    run_case(0, 0, 1, "R8 clamp N=0 P=1");
    run_case(3, 2, 0, "R8 clamp P=0");
    for (int r = 12; r <= 20; r++)
      run_case(r / 4, r % 4, 4, "R9 consecutive ratios P=4");
    for (int i = 0; i < 24; i++) begin
      int p = 2 + int'($urandom % 11);
      int n = 1 + int'($urandom % 20);
      int amax = (n < p - 1) ? n : p - 1;
      int a = int'($urandom % (amax + 1));
      run_case(n, a, p, "R2 random");
    end
    check("R3 div_o never two clocks", dbl_div, 0);
    report();
  end
endmodule